// File: doc/BRIEF.md
# TDM Receive Time-Slot Router

This block takes the receive side of one time-division-multiplexed serial port (a bit clock, a frame-sync pulse and a serial data line) and splits each frame into runs addressed to up to seven downstream byte FIFOs. A table held in a 256-word routing memory steers each run. The memory is split into four 64-word banks. A bank-map register binds the port to one of the four banks. Each table word names a destination, a channel tag, a run length of one to eight units, and whether a unit is one bit or a whole byte. One flag marks the last word of the frame, and another swaps the serial input for the local loopback line.

Software fills the memory and the control registers through a single write port before traffic starts. The table alone sets the frame length. The bit-clock edge, a double-rate clock mode and the gap between frame sync and the first data bit are all programmable. A frame sync that arrives in the middle of a frame restarts the table and latches a sticky error flag.

Top module: `tdm_slot_router`

## Requirements
- R1: A write with cfg_addr[8]=0 stores cfg_wdata at memory word cfg_addr[7:0]. The port reads only the 64 words of its bound bank, starting at word bank*64 with index 0.
- R2: The bank-map register sits at cfg_addr 0x100. Port p's bank is held in bits [2p+1:2p], and the reset value is 0xE4. A write that gives two ports the same bank is ignored.
- R3: A table word routes ([13:11]+1) consecutive units to one destination. Words are used in rising index order from index 0 at each frame start.
- R4: Byte mode (word bit 14 = 1) collects 8 bits MSB-first and issues one write with fifo_bit=0.
- R5: Bit mode (bit 14 = 0) issues one write per bit. The bit appears on fifo_data[0], fifo_data[7:1] is zero, and fifo_bit=1.
- R6: A destination field [9:7] equal to 7 consumes its units and issues no write.
- R7: After the last unit of a word with bit 15 set, frame_active drops. No write occurs until the next rising frame sync.
- R8: Mode register bits [4:2] hold a lead L. The first data bit is the one sampled L samples after the sample that first sees frame sync high.
- R9: Mode register (0x101) bit 0 picks the sampling edge (0 rising, 1 falling). Bit 1 selects double-rate mode, which samples on every second selected edge.
- R10: In a word with bit 10 set, its units take lb_data instead of sdata.
- R11: A rising frame sync while frame_active is high restarts the table at index 0 and sets sync_err. sync_err stays set until a write to 0x102 with bit 0 = 1.
- R12: Each write raises exactly one fifo_we bit, the one at the destination's index, with fifo_chan set to word bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| sdata | input | 1 | Serial receive data |
| lb_data | input | 1 | Local transmit data used for loopback |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Memory word (bit 8 = 0) or register (bit 8 = 1) |
| cfg_wdata | input | 16 | Configuration write data |
| fifo_we | output | 7 | One-hot FIFO write enable per destination |
| fifo_chan | output | 7 | Channel tag of the write |
| fifo_data | output | 8 | Byte or single bit being written |
| fifo_bit | output | 1 | High when only fifo_data[0] is valid |
| frame_active | output | 1 | A frame is being routed |
| sync_err | output | 1 | Sticky early frame-sync flag |
| bank_map | output | 8 | Current port-to-bank bindings |

## Verification
The first frame mixes byte runs, bit runs, a discarded run and a closing byte word, with a one-sample lead on rising edges. A mismatch there separates errors in byte assembly order, run counting and drop handling. The same table is then run with falling edges, double rate, zero lead and one word switched to loopback, while lb_data carries the inverse of sdata, so a wrong edge, divider or input select shows up as wrong bits. A remap to a two-word bank (one useful word plus an empty partner) shows that the bank binding really picks the memory region. An early second frame sync must produce the restarted write sequence together with the error flag. Bits sent after each frame's end word must produce no writes at all.

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
  parameter int PORT_ID = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        fsync,
  input  logic        sdata,
  input  logic        lb_data,
  input  logic        cfg_we,
  input  logic [8:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  output logic [6:0]  fifo_we,
  output logic [6:0]  fifo_chan,
  output logic [7:0]  fifo_data,
  output logic        fifo_bit,
  output logic        frame_active,
  output logic        sync_err,
  output logic [7:0]  bank_map
);
  localparam int BANKS = 4;
  localparam int DEPTH = 64;
  localparam int PW    = $clog2(DEPTH);
  localparam int BW    = $clog2(BANKS);
  localparam int RAM_N = BANKS * DEPTH;
  localparam logic [2:0] DROP = 3'd7;

  function automatic logic map_legal(input logic [7:0] m);
    map_legal = 1'b1;
    for (int i = 0; i < BANKS; i++)
      for (int j = i + 1; j < BANKS; j++)
        if (m[BW*i +: BW] == m[BW*j +: BW]) map_legal = 1'b0;
  endfunction

  logic [15:0]   rt_mem [RAM_N];
  logic [3:0]    syn1, syn2;
  logic          bclk_d, half_ph;
  logic          edge_sel, mode_2x;
  logic [2:0]    lead_cfg, lead_cnt, unit_cnt, bit_cnt;
  logic          fs_prev;
  logic [PW-1:0] ptr;
  logic [6:0]    shreg;

  wire reg_wr = cfg_we & cfg_addr[8];
  wire map_wr = reg_wr & (cfg_addr[1:0] == 2'd0);
  wire mod_wr = reg_wr & (cfg_addr[1:0] == 2'd1);
  wire clr_wr = reg_wr & (cfg_addr[1:0] == 2'd2) & cfg_wdata[0];

  always_ff @(posedge clk)
    if (cfg_we && !cfg_addr[8]) rt_mem[cfg_addr[7:0]] <= cfg_wdata;

  wire s_bclk = syn2[3];
  wire s_fs   = syn2[2];
  wire s_sd   = syn2[1];
  wire s_lb   = syn2[0];

  wire edge_hit = edge_sel ? (bclk_d & ~s_bclk) : (~bclk_d & s_bclk);
  wire strobe   = edge_hit & (~mode_2x | half_ph);

  wire          fs_start = strobe & s_fs & ~fs_prev;
  wire          go       = strobe & (fs_start | frame_active);
  wire [PW-1:0] c_ptr    = fs_start ? '0 : ptr;
  wire [2:0]    c_unit   = fs_start ? 3'd0 : unit_cnt;
  wire [2:0]    c_bitc   = fs_start ? 3'd0 : bit_cnt;
  wire [2:0]    c_lead   = fs_start ? lead_cfg : lead_cnt;
  wire [BW-1:0] my_bank  = bank_map[BW*PORT_ID +: BW];
  wire [15:0]   ent      = rt_mem[{my_bank, c_ptr}];

  wire       e_end  = ent[15];
  wire       e_byte = ent[14];
  wire [2:0] e_cnt  = ent[13:11];
  wire       e_lb   = ent[10];
  wire [2:0] e_dst  = ent[9:7];
  wire [6:0] e_ch   = ent[6:0];

  wire take      = go & (c_lead == 3'd0);
  wire in_bit    = e_lb ? s_lb : s_sd;
  wire unit_done = ~e_byte | (c_bitc == 3'd7);
  wire ent_done  = unit_done & (c_unit == e_cnt);
  wire emit      = take & unit_done & (e_dst != DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn1     <= '0;
      syn2     <= '0;
      bclk_d   <= 1'b0;
      half_ph  <= 1'b0;
      edge_sel <= 1'b0;
      mode_2x  <= 1'b0;
      lead_cfg <= '0;
      bank_map <= 8'hE4;
    end else begin
      syn1   <= {bclk, fsync, sdata, lb_data};
      syn2   <= syn1;
      bclk_d <= s_bclk;
      if (edge_hit) half_ph <= ~half_ph;
      if (map_wr && map_legal(cfg_wdata[7:0])) bank_map <= cfg_wdata[7:0];
      if (mod_wr) {lead_cfg, mode_2x, edge_sel} <= cfg_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev      <= 1'b0;
      frame_active <= 1'b0;
      sync_err     <= 1'b0;
      lead_cnt     <= '0;
      unit_cnt     <= '0;
      bit_cnt      <= '0;
      ptr          <= '0;
      shreg        <= '0;
    end else begin
      if (strobe) fs_prev <= s_fs;
      if (fs_start && frame_active) sync_err <= 1'b1;
      else if (clr_wr)              sync_err <= 1'b0;
      if (go) begin
        lead_cnt     <= take ? 3'd0 : c_lead - 3'd1;
        bit_cnt      <= (take && e_byte && !unit_done) ? c_bitc + 3'd1 : 3'd0;
        unit_cnt     <= (take && ent_done) ? 3'd0 :
                        (take && unit_done) ? c_unit + 3'd1 : c_unit;
        ptr          <= (take && ent_done) ? c_ptr + 1'b1 : c_ptr;
        frame_active <= ~(take & ent_done & e_end);
        if (take) shreg <= {shreg[5:0], in_bit};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_we   <= '0;
      fifo_chan <= '0;
      fifo_data <= '0;
      fifo_bit  <= 1'b0;
    end else begin
      fifo_we <= emit ? (7'd1 << e_dst) : 7'd0;
      if (emit) begin
        fifo_chan <= e_ch;
        fifo_data <= e_byte ? {shreg, in_bit} : {7'd0, in_bit};
        fifo_bit  <= ~e_byte;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_router_chk.sv
module tdm_slot_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [8:0]  cfg_addr,
  input logic [15:0] cfg_wdata,
  input logic [6:0]  fifo_we,
  input logic [7:0]  fifo_data,
  input logic        fifo_bit,
  input logic        sync_err,
  input logic [7:0]  bank_map
);
  function automatic logic distinct4(input logic [7:0] m);
    distinct4 = 1'b1;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (m[2*i +: 2] == m[2*j +: 2]) distinct4 = 1'b0;
  endfunction

  wire map_try = cfg_we && cfg_addr == 9'h100;
  wire clr_try = cfg_we && cfg_addr == 9'h102 && cfg_wdata[0];

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fifo_we)); // R12
  AST_BIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we != 0 && fifo_bit) |-> fifo_data[7:1] == 7'd0); // R5
  AST_MAP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) distinct4(bank_map)); // R2
  AST_DUP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (map_try && !distinct4(cfg_wdata[7:0])) |=> $stable(bank_map)); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !clr_try) |=> sync_err); // R11
endmodule

bind tdm_slot_router tdm_slot_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .fifo_we(fifo_we), .fifo_data(fifo_data),
  .fifo_bit(fifo_bit), .sync_err(sync_err), .bank_map(bank_map)
);

// File: tb/tdm_slot_router_tb_top.sv
module tdm_slot_router_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdata = 1'b0, lb_data = 1'b0;
  logic cfg_we = 1'b0;
  logic [8:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [6:0] fifo_we, fifo_chan;
  logic [7:0] fifo_data, bank_map;
  logic fifo_bit, frame_active, sync_err;

  always #4 clk = ~clk;

  tdm_slot_router dut_i (.*);

  int n_checks = 0, n_fail = 0;
  logic [22:0] exp_q[$];
  logic [15:0] tbl [256];
  logic [7:0] m_map = 8'hE4;
  logic m_edge = 0, m_2x = 0;
  int m_leadcfg = 0, m_lead = 0, m_ptr = 0, m_unit = 0, m_bitc = 0;
  logic m_active = 0, m_fsprev = 0, m_err = 0;
  logic [7:0] m_sh = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a[8] && a[1:0] == 2'd0) begin
      logic ok = 1;
      for (int i = 0; i < 4; i++)
        for (int j = i + 1; j < 4; j++)
          if (d[2*i +: 2] == d[2*j +: 2]) ok = 0;
      if (ok) m_map = d[7:0];
    end else if (a[8] && a[1:0] == 2'd1) begin
      m_edge = d[0]; m_2x = d[1]; m_leadcfg = int'(d[4:2]);
    end else if (a[8] && a[1:0] == 2'd2 && d[0]) m_err = 0;
    else if (!a[8]) tbl[a[7:0]] = d;
  endtask

  // behavioural model of one sampled bit
  task automatic model_bit(input logic d, input logic f, input logic l);
    logic [15:0] e; logic b; int dst;
    if (f && !m_fsprev) begin
      if (m_active) m_err = 1;   // R11
      m_active = 1; m_ptr = 0; m_unit = 0; m_bitc = 0; m_lead = m_leadcfg;
    end
    m_fsprev = f;
    if (!m_active) return;
    if (m_lead > 0) begin m_lead--; return; end   // R8
    e = tbl[int'(m_map[1:0]) * 64 + m_ptr];        // R1
    b = e[10] ? l : d;                             // R10
    dst = int'(e[9:7]);
    if (e[14]) begin
      m_sh = {m_sh[6:0], b};
      m_bitc++;
      if (m_bitc < 8) return;
      m_bitc = 0;
      if (dst != 7) exp_q.push_back({7'(1 << dst), e[6:0], 1'b0, m_sh});
    end else if (dst != 7) exp_q.push_back({7'(1 << dst), e[6:0], 1'b1, 7'd0, b});
    if (m_unit == int'(e[13:11])) begin
      m_unit = 0; m_ptr = (m_ptr + 1) % 64;
      if (e[15]) m_active = 0;                     // R7
    end else m_unit++;
  endtask

  task automatic send_bit(input logic d, input logic f, input logic l);
    model_bit(d, f, l);
    for (int k = 0; k < (m_2x ? 2 : 1); k++) begin
      if (k == 0) begin sdata = d; fsync = f; lb_data = l; end
      bclk = m_edge;  repeat (4) @(negedge clk);
      bclk = ~m_edge; repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic rbit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send_frame(input int nbits, input bit inv_lb);
    logic d;
    repeat (2) send_bit(rbit(), 0, 0);
    for (int i = 0; i < m_leadcfg; i++) send_bit(rbit(), i == 0, 0);
    for (int i = 0; i < nbits; i++) begin
      d = rbit();
      send_bit(d, (m_leadcfg == 0) && (i == 0), inv_lb ? ~d : d);
    end
  endtask

  task automatic settle_idle(input string tag);
    repeat (5) send_bit(rbit(), 0, rbit());   // R7: ignored after end word
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, {tag, " missing writes"}, exp_q.size(), 0);
    check(frame_active == 1'b0, {tag, " frame_active after end"}, frame_active, 0);
  endtask

  always @(negedge clk) if (rst_n && fifo_we != 0) begin
    logic [22:0] got, e;
    got = {fifo_we, fifo_chan, fifo_bit, fifo_data};
    if (exp_q.size() == 0) check(0, "R7/R6 unexpected write", int'(got), 0);
    else begin
      e = exp_q.pop_front();
      // R3 R4 R5 R12: order, data, qualifier, destination, channel
      check(got == e, "R12 write content", int'(got), int'(e));
    end
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fifo_we == 0, "R12 reset fifo_we", fifo_we, 0);
    check(sync_err == 0, "R11 reset sync_err", sync_err, 0);
    check(frame_active == 0, "R7 reset frame_active", frame_active, 0);
    check(bank_map == 8'hE4, "R2 reset bank_map", bank_map, 8'hE4);
    rst_n = 1;
    repeat (3) @(negedge clk);

    cfg_write(9'h100, 16'h00E0);
    check(bank_map == 8'hE4, "R2 duplicate map rejected", bank_map, 8'hE4);
    cfg_write(9'h100, 16'h001B);
    check(bank_map == 8'h1B, "R2 legal map accepted", bank_map, 8'h1B);

    // bank 3 table: byte x2 dst2, bit x3 dst0, drop x4, byte x1 dst6 end
    cfg_write(9'd192, {1'b0, 1'b1, 3'd1, 1'b0, 3'd2, 7'd5});
    cfg_write(9'd193, {1'b0, 1'b0, 3'd2, 1'b0, 3'd0, 7'd9});
    cfg_write(9'd194, {1'b0, 1'b0, 3'd3, 1'b0, 3'd7, 7'd0});
    cfg_write(9'd195, {1'b1, 1'b1, 3'd0, 1'b0, 3'd6, 7'd127});
    // bank 0 table: one bit to dst1, paired empty end word
    cfg_write(9'd0, {1'b0, 1'b0, 3'd0, 1'b0, 3'd1, 7'd3});
    cfg_write(9'd1, {1'b1, 1'b0, 3'd0, 1'b0, 3'd7, 7'd0});

    cfg_write(9'h101, {11'd0, 3'd1, 1'b0, 1'b0});   // R8 lead 1, R9 rising 1x
    send_frame(31, 0);
    settle_idle("R3 frame A");

    cfg_write(9'd193, {1'b0, 1'b0, 3'd2, 1'b1, 3'd0, 7'd9});  // R10 loopback
    cfg_write(9'h101, {11'd0, 3'd0, 1'b1, 1'b1});   // R9 falling 2x, R8 lead 0
    send_frame(31, 1);
    settle_idle("R9 frame B");

    cfg_write(9'h100, 16'h00E4);                    // R1 back to bank 0
    cfg_write(9'h101, {11'd0, 3'd2, 1'b0, 1'b0});
    send_frame(2, 0);
    settle_idle("R1 frame C");

    cfg_write(9'h100, 16'h001B);
    cfg_write(9'h101, {11'd0, 3'd0, 1'b0, 1'b0});
    send_frame(10, 0);
    for (int i = 0; i < 31; i++) send_bit(rbit(), i == 0, 0);  // R11 early sync
    settle_idle("R11 frame D");
    check(sync_err == m_err && m_err, "R11 sticky error set", sync_err, 1);
    cfg_write(9'h102, 16'h0001);
    check(sync_err == 1'b0, "R11 error cleared", sync_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule